// File: doc/BRIEF.md
# Three-Channel Compare Timer

This peripheral is a free-running or self-restarting up-counter with three absolute-value compare channels, reached through a plain register bus: address, write data, write strobe and combinational read data. The count source is one of five tick-enable inputs, all in the block's single clock domain, chosen by a control field. A prescaler divides the chosen ticks before they reach the counter. Software uses the block as a timebase by reading the counter. It uses the block as an event source by loading a compare value, enabling that channel's interrupt and clearing the status flag once the event has been handled.

Counting continues only while the global enable is set. It also needs every asserted low-power-mode input (wait, doze, stop, debug) to be matched by its run-enable bit in control. A self-clearing software reset returns the block to a known state and keeps the clock choice and the low-power run bits, so a driver can pick a clock, reset, and then start counting.

Top module: `cmpt_timer`

## Requirements
- R1: After the synchronous reset, control, prescaler, status and interrupt-enable read 0, every compare register reads all-ones (CNT_W bits, zero-extended), the counter reads 0 and `irq` is low.
- R2: The counter advances by one on each prescaled tick. In free-run mode it wraps from all-ones (CNT_W bits) to zero.
- R3: The prescaler register (0x04) holds n-1 and gives one counter step per n selected ticks. Writing it restarts the division.
- R4: Control bits [7:5] select the tick input: 1..4 pick src_tick[0..3], 5 picks src_tick[4] only while control bit 9 is set, and 0, 6 and 7 pick no source.
- R5: The counter holds its value while control bit 0 (enable) is clear.
- R6: While lp_wait, lp_doze, lp_stop or lp_debug is high, the counter holds unless control bit 1, 2, 3 or 4 respectively is set.
- R7: Status bit i (register 0x08) sets when the counter steps onto the value in compare register i+1 (0x10, 0x14, 0x18) and stays set until cleared.
- R8: With control bit 8 (free-run) set, a channel 1 match does not disturb counting.
- R9: With control bit 8 clear, the step after the counter equals compare 1 loads zero, so the count period is compare 1 plus one.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly while some status bit and the same interrupt-enable bit (register 0x0C, bits [2:0]) are both set.
- R12: Writing control with bit 15 set starts a software reset. Bit 15 then reads 1 for SWR_CYCLES cycles and 0 afterwards. Control keeps bits [7:1] and 9 and clears bits 0 and 8. Prescaler, status, enables, counter and compares return to their R1 values, and bus writes during the reset are ignored.
- R13: The counter is read at 0x24 and writes to it have no effect. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 5 | Tick enables: peripheral, fast peripheral, external, slow, 24 MHz |
| lp_wait | input | 1 | Wait mode active |
| lp_doze | input | 1 | Doze mode active |
| lp_stop | input | 1 | Stop mode active |
| lp_debug | input | 1 | Debug halt active |
| irq | output | 1 | Level interrupt |

## Verification
The counter wrap is the hardest case to reach from the ports. The counter cannot be written, so the bench would need four billion ticks to wrap it at full width. The bench instead builds the block with an 8-bit counter and a 4-bit prescaler, which makes a wrap cost 256 ticks. Every source select, prescale value, low-power mode combination and restart period can then be swept in full. A software reset before each case brings the block back to a known state, and the bench also issues writes inside the reset window to show that they are dropped.

// File: rtl/cmpt_pkg.sv
// Package: register offsets, control-register layout and source codes
// shared by every module of the compare timer.
package cmpt_pkg;
    localparam logic [7:0] A_CTRL     = 8'h00;
    localparam logic [7:0] A_PRE      = 8'h04;
    localparam logic [7:0] A_STS      = 8'h08;
    localparam logic [7:0] A_IE       = 8'h0C;
    localparam logic [7:0] A_CMP_BASE = 8'h10;
    localparam logic [7:0] A_CNT      = 8'h24;

    localparam int CR_SRST  = 15;  // self-clearing software reset
    localparam int CR_BITS  = 10;  // stored control bits [9:0]

    // Stored control fields, MSB first so a cast from wdata[9:0] lines up.
    typedef struct packed {
        logic       x24_en;    // bit 9
        logic       free;      // bit 8
        logic [2:0] sel;       // bits 7:5
        logic       dbg_run;   // bit 4
        logic       stop_run;  // bit 3
        logic       doze_run;  // bit 2
        logic       wait_run;  // bit 1
        logic       en;        // bit 0
    } ctrl_t;

    typedef enum logic [2:0] {
        SRC_OFF   = 3'd0,
        SRC_PER   = 3'd1,
        SRC_PERHI = 3'd2,
        SRC_EXT   = 3'd3,
        SRC_SLOW  = 3'd4,
        SRC_X24   = 3'd5
    } src_e;

    localparam int N_SRC = 5;
endpackage

// File: rtl/cmpt_prescale.sv
// Prescaler: picks one tick input by source code and emits one counter
// step per (pr_val+1) picked ticks while run_ok is high.
// Assumes ticks are single-cycle enables in the clk domain.
module cmpt_prescale
    import cmpt_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           src_sel,
    input  logic                 x24_en,
    input  logic [N_SRC-1:0]     src_tick,
    input  logic                 run_ok,
    input  logic [PRE_W-1:0]     pr_val,
    input  logic                 pr_clr,
    output logic                 step
);
    logic             tick_pick;
    logic [PRE_W-1:0] pcnt_q;

    // Route the selected source; the 24 MHz input also needs its enable.
    always_comb begin
        case (src_sel)
            SRC_PER:   tick_pick = src_tick[0];
            SRC_PERHI: tick_pick = src_tick[1];
            SRC_EXT:   tick_pick = src_tick[2];
            SRC_SLOW:  tick_pick = src_tick[3];
            SRC_X24:   tick_pick = src_tick[4] & x24_en;
            default:   tick_pick = 1'b0;
        endcase
    end

    assign step = run_ok && tick_pick && (pcnt_q == pr_val);

    // Divide counter: counts picked ticks, restarts on terminal or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || pr_clr)
            pcnt_q <= '0;
        else if (run_ok && tick_pick)
            pcnt_q <= step ? '0 : pcnt_q + 1'b1;
    end

    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pr_val != '0 && !pr_clr) |=> !step); // R3
endmodule

// File: rtl/cmpt_counter.sv
// Main up-counter: steps on the prescaled tick, loads zero on a restart
// request, wraps naturally at all-ones; clr holds it at zero.
module cmpt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    // Next-count selection.
    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else if (step)
            cnt_nxt = restart ? '0 : cnt_q + 1'b1;
        else
            cnt_nxt = cnt_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt_q)); // R5
    AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !clr) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (step && restart && !clr) |=> cnt_q == '0); // R9
endmodule

// File: rtl/cmpt_channel.sv
// One compare channel: holds an absolute compare value and a sticky flag
// that sets when the counter steps onto that value; write-1 clears it.
module cmpt_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             w1c,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_q,
    output logic             eq_now
);
    logic hit;

    assign hit    = step && !clr && (cnt_nxt == cmp_q);
    assign eq_now = (cnt_q == cmp_q);

    // Compare value register, all-ones after any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cmp_q <= '1;
        else if (cmp_we)   cmp_q <= cmp_wdata;
    end

    // Sticky match flag; a new hit wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (w1c)      flag_q <= 1'b0;
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !w1c && !clr) |=> flag_q); // R10
endmodule

// File: rtl/cmpt_timer.sv
// Top of the compare timer: register decode, control/prescaler/enable
// registers, software-reset sequencer, low-power run gating and irq.
// Assumes one bus access per cycle, word-aligned addresses, CNT_W <= 32.
module cmpt_timer
    import cmpt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PRE_W      = 12,
    parameter int SWR_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_we,
    output logic [31:0] bus_rdata,
    input  logic [4:0]  src_tick,
    input  logic        lp_wait,
    input  logic        lp_doze,
    input  logic        lp_stop,
    input  logic        lp_debug,
    output logic        irq
);
    localparam int N_CH  = 3;
    localparam int BSY_W = $clog2(SWR_CYCLES + 1);

    ctrl_t            ctrl_q;
    logic [PRE_W-1:0] pr_q;
    logic [N_CH-1:0]  ie_q;
    logic [BSY_W-1:0] bsy_q;
    logic             busy, wr_ok, srst_req, run_ok, step, restart;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [CNT_W-1:0] cmp_v [N_CH];
    logic [N_CH-1:0]  sts, ch_eq;

    assign busy     = (bsy_q != '0);
    assign wr_ok    = bus_we && !busy;
    assign srst_req = wr_ok && bus_addr == A_CTRL && bus_wdata[CR_SRST];

    // Control register; a reset request keeps clock and mode-run fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (srst_req) begin
            ctrl_q.en   <= 1'b0;
            ctrl_q.free <= 1'b0;
        end else if (wr_ok && bus_addr == A_CTRL)
            ctrl_q <= ctrl_t'(bus_wdata[CR_BITS-1:0]);
    end

    // Software-reset window: loads the length, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        bsy_q <= '0;
        else if (srst_req) bsy_q <= BSY_W'(SWR_CYCLES);
        else if (busy)     bsy_q <= bsy_q - 1'b1;
    end

    // Prescaler and interrupt-enable registers, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            pr_q <= '0;
            ie_q <= '0;
        end else if (wr_ok) begin
            if (bus_addr == A_PRE) pr_q <= bus_wdata[PRE_W-1:0];
            if (bus_addr == A_IE)  ie_q <= bus_wdata[N_CH-1:0];
        end
    end

    // Run gating: global enable, not resetting, every active mode allowed.
    always_comb begin
        run_ok = ctrl_q.en && !busy
              && !(lp_wait  && !ctrl_q.wait_run)
              && !(lp_doze  && !ctrl_q.doze_run)
              && !(lp_stop  && !ctrl_q.stop_run)
              && !(lp_debug && !ctrl_q.dbg_run);
    end

    cmpt_prescale #(.PRE_W(PRE_W)) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (ctrl_q.sel),
        .x24_en   (ctrl_q.x24_en),
        .src_tick (src_tick),
        .run_ok   (run_ok),
        .pr_val   (pr_q),
        .pr_clr   (busy || (wr_ok && bus_addr == A_PRE)),
        .step     (step)
    );

    assign restart = !ctrl_q.free && ch_eq[0];

    cmpt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (busy),
        .step    (step),
        .restart (restart),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [7:0] A_ME = 8'(A_CMP_BASE + 4 * i);
        cmpt_channel #(.CNT_W(CNT_W)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (busy),
            .cmp_we    (wr_ok && bus_addr == A_ME),
            .cmp_wdata (bus_wdata[CNT_W-1:0]),
            .w1c       (wr_ok && bus_addr == A_STS && bus_wdata[i]),
            .step      (step),
            .cnt_q     (cnt_q),
            .cnt_nxt   (cnt_nxt),
            .cmp_q     (cmp_v[i]),
            .flag_q    (sts[i]),
            .eq_now    (ch_eq[i])
        );
    end

    assign irq = |(sts & ie_q);

    // Read mux; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {16'd0, busy, 5'd0, ctrl_q};
            A_PRE:  bus_rdata = 32'(pr_q);
            A_STS:  bus_rdata = 32'(sts);
            A_IE:   bus_rdata = 32'(ie_q);
            8'h10:  bus_rdata = 32'(cmp_v[0]);
            8'h14:  bus_rdata = 32'(cmp_v[1]);
            8'h18:  bus_rdata = 32'(cmp_v[2]);
            A_CNT:  bus_rdata = 32'(cnt_q);
            default: bus_rdata = '0;
        endcase
    end

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt_q == '0 && sts == '0 && pr_q == '0 && ie_q == '0)); // R12
    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq); // R11
endmodule

// File: tb/cmpt_timer_tb_top.sv
// Bench: sweeps a narrow configuration (8-bit counter, 4-bit prescaler)
// and computes every expected value arithmetically.
module cmpt_timer_tb_top;
    localparam int SWR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [4:0]  src_tick = '0;
    logic        lp_wait = 0, lp_doze = 0, lp_stop = 0, lp_debug = 0;
    logic        irq;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    cmpt_timer #(.CNT_W(8), .PRE_W(4), .SWR_CYCLES(SWR)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .lp_wait(lp_wait), .lp_doze(lp_doze), .lp_stop(lp_stop),
        .lp_debug(lp_debug), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_ticks(input logic [4:0] m, input int n);
        @(negedge clk);
        src_tick = m;
        repeat (n) @(negedge clk);
        src_tick = '0;
    endtask

    task automatic fresh();
        wr(8'h00, 32'h8000);
        repeat (SWR + 1) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h04, v); chk("R1 pre", v, 0);
        rd(8'h08, v); chk("R1 sts", v, 0);
        rd(8'h0C, v); chk("R1 ie", v, 0);
        for (int i = 0; i < 3; i++) begin
            rd(8'(8'h10 + 4 * i), v); chk("R1 cmp", v, 32'hFF);
        end
        rd(8'h24, v); chk("R1 cnt", v, 0);
        chk("R1 irq", irq, 0);
        // R13 unmapped reads
        rd(8'h1C, v); chk("R13 unmapped", v, 0);
        rd(8'h20, v); chk("R13 unmapped", v, 0);
        rd(8'h28, v); chk("R13 unmapped", v, 0);

        // R4 source select sweep, with R5 enable off case
        for (int s = 0; s < 8; s++)
            for (int f = 0; f < 2; f++)
                for (int ln = 0; ln < 5; ln++) begin
                    int e;
                    fresh();
                    wr(8'h00, 32'h101 | (s << 5) | (f << 9));
                    run_ticks(5'(1 << ln), 5);
                    rd(8'h24, v);
                    e = (s >= 1 && s <= 5 && ln == s - 1 && (s != 5 || f == 1)) ? 5 : 0;
                    chk("R4 source", v, e);
                end
        fresh();
        wr(8'h00, 32'h120);
        run_ticks(5'h1F, 6);
        rd(8'h24, v); chk("R5 enable off", v, 0);

        // R3 prescaler sweep
        for (int p = 0; p < 8; p++) begin
            fresh();
            wr(8'h04, p);
            wr(8'h00, 32'h121);
            run_ticks(5'h01, 24);
            rd(8'h24, v); chk("R3 prescale", v, 24 / (p + 1));
        end

        // R6 low-power mode gating
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 2; r++) begin
                fresh();
                wr(8'h00, 32'h121 | (r << (m + 1)));
                lp_wait = (m == 0); lp_doze = (m == 1);
                lp_stop = (m == 2); lp_debug = (m == 3);
                run_ticks(5'h01, 6);
                lp_wait = 0; lp_doze = 0; lp_stop = 0; lp_debug = 0;
                rd(8'h24, v); chk("R6 mode run", v, r ? 6 : 0);
            end

        // R7/R8 compare flags in free-run mode
        fresh();
        wr(8'h10, 5); wr(8'h14, 7); wr(8'h18, 9);
        wr(8'h00, 32'h121);
        run_ticks(5'h01, 6);
        rd(8'h08, v); chk("R7 partial flags", v, 1);
        run_ticks(5'h01, 6);
        rd(8'h24, v); chk("R8 no restart", v, 12);
        rd(8'h08, v); chk("R7 all flags", v, 7);
        // R11 irq over every enable pattern
        for (int e = 0; e < 8; e++) begin
            wr(8'h0C, e);
            chk("R11 irq", irq, e != 0);
        end
        // R10 write-1-to-clear
        wr(8'h08, 32'h2);
        rd(8'h08, v); chk("R10 w1c", v, 5);
        wr(8'h08, 32'h0);
        rd(8'h08, v); chk("R10 write zero", v, 5);
        wr(8'h0C, 32'h2);
        chk("R11 irq masked", irq, 0);
        // R13 counter is read-only
        wr(8'h24, 32'h55);
        rd(8'h24, v); chk("R13 cnt readonly", v, 12);

        // R9 restart period sweep
        for (int c = 1; c < 5; c++) begin
            fresh();
            wr(8'h10, c);
            wr(8'h00, 32'h021);
            run_ticks(5'h01, 10);
            rd(8'h24, v); chk("R9 restart", v, 10 % (c + 1));
            rd(8'h08, v); chk("R9 ch1 flag", v & 1, 1);
        end

        // R2 wrap through all-ones
        fresh();
        wr(8'h00, 32'h121);
        run_ticks(5'h01, 260);
        rd(8'h24, v); chk("R2 wrap", v, 4);

        // R12 software reset sequence
        wr(8'h04, 3); wr(8'h0C, 5); wr(8'h10, 32'h20);
        wr(8'h00, 32'h393);
        wr(8'h00, 32'h8000);
        for (int k = 0; k <= SWR; k++) begin
            rd(8'h00, v); chk("R12 busy bit", v[15], k < SWR);
            if (k == 0) begin
                wr(8'h0C, 7); // lands inside the reset window
                k++;
            end else
                @(negedge clk);
        end
        rd(8'h00, v); chk("R12 kept ctrl", v, 32'h292);
        rd(8'h04, v); chk("R12 pre cleared", v, 0);
        rd(8'h0C, v); chk("R12 write ignored", v, 0);
        rd(8'h10, v); chk("R12 cmp restored", v, 32'hFF);
        rd(8'h24, v); chk("R12 cnt cleared", v, 0);
        rd(8'h08, v); chk("R12 sts cleared", v, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule